// File: doc/BRIEF.md
# Chained DMA Buffer Register Controller

This block holds the double-buffered address and byte-count state of a single DMA channel that runs in chained-buffer mode. The host programs the *next* buffer (target address and count) into a staging set. The transfer engine works from an *active* set. When the engine reports that the active buffer has run out, the staged values move into the active set in that same clock edge. The staging set is then empty again, and the block raises an interrupt asking the host to refill it.

The interrupt means only "staging set empty". It is withdrawn by exactly one event: a write of the most significant address byte, which commits the whole staged set. If the active buffer runs out while the staging set is still empty, the host has missed its window. The chain ends and the channel goes idle. The channel mask pauses the chain without losing any state. The most significant address byte lives only in the extended register region. While only the legacy map is decoded, that byte cannot be written, so the chain can never be refilled.

Top module: `bufchain_ctrl`

## Requirements
- R1: After a synchronous reset, `cur_addr` and `cur_cnt` read zero, `irq` and `chain_active` are low, the staging set is empty and the channel mask is set.
- R2: A write with `wr_en` high decodes `wr_sel` as follows. Codes 0 to ADDR_BYTES-1 each load one staging address byte from `wr_data[7:0]`, with code k going to address bits 8k+7:8k. Code 4 loads the staging count from `wr_data`. Code 5 writes the chaining enable from `wr_data[0]`. Code 6 writes the mask from `wr_data[0]`. Any other code has no effect.
- R3: A write of 1 to the chaining enable while chaining is off sets `chain_active` and `irq` on the next cycle and marks the staging set empty. Writing 1 while chaining is already on changes nothing.
- R4: A write to code ADDR_BYTES-1 (the most significant address byte) marks the staging set full and drops `irq` on the next cycle. Writes to the lower address bytes or to the count leave `irq` unchanged.
- R5: A `buf_exp` pulse while chaining is on, the channel is unmasked and the staging set is full copies the staged address and count into `cur_addr`/`cur_cnt` on the next cycle. It also empties the staging set and raises `irq`.
- R6: A `buf_exp` pulse while chaining is on, the channel is unmasked and the staging set is empty ends the chain. On the next cycle `chain_active` and `irq` are low and `cur_addr`/`cur_cnt` are unchanged.
- R7: Writing 0 to the chaining enable clears `chain_active` and removes any pending `irq` on the next cycle.
- R8: While the mask is set, `buf_exp` is ignored and the staged and current contents are kept. Clearing the mask resumes the chain from the same state.
- R9: While `ext_map_en` is low, a write to the most significant address byte is ignored. The byte is not stored, the staging set stays as it was, and `irq` is unchanged. Lower address bytes and the count are still accepted.
- R10: A most-significant-byte write in the same cycle as an accepted `buf_exp` with an empty staging set counts as in time. The newly written values go straight to the current set, the staging set stays empty and `irq` stays high.
- R11: `buf_exp` while chaining is off, or in the same cycle as a write that changes the chaining enable, has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select code (see R2) |
| wr_data | input | CNT_W | Write data |
| ext_map_en | input | 1 | High when the extended register region is decoded |
| buf_exp | input | 1 | Active buffer expired, one-cycle pulse from the transfer engine |
| cur_addr | output | 8*ADDR_BYTES | Active buffer target address |
| cur_cnt | output | CNT_W | Active buffer byte count |
| irq | output | 1 | Staging set empty, refill requested |
| chain_active | output | 1 | Chaining is running |

## Verification
The bench aims at the timing races. One is an expiry landing in the same cycle as the committing byte write. A design that gives the expiry priority would end a chain that the host refilled in time. A design that loads the old staged values would transfer from a stale address. The bench drives lower-byte and count writes while the interrupt is pending, and writes the top byte with the extended region disabled. A design that commits on the wrong byte would drop the interrupt early, or accept a buffer it cannot address. It also fires expiries while masked, while chaining is off, and in the cycle chaining is switched. A design that lets any of these through would shift the current registers or end the chain by surprise. That would appear as a mismatch against the cycle model.

// File: rtl/bufchain_pkg.sv
package bufchain_pkg;

    localparam logic [2:0] SEL_CNT   = 3'd4;
    localparam logic [2:0] SEL_CHAIN = 3'd5;
    localparam logic [2:0] SEL_MASK  = 3'd6;

    typedef enum logic [1:0] {
        EVT_NONE = 2'd0,
        EVT_LOAD = 2'd1,
        EVT_TERM = 2'd2
    } exp_evt_t;

    // True when select code hits address byte idx and that byte is reachable
    function automatic logic addr_byte_hit(logic [2:0] sel, int idx, int msb_idx, logic ext);
        return (sel[2] == 1'b0) && (int'(sel[1:0]) == idx) && ((idx != msb_idx) || ext);
    endfunction

endpackage

// File: rtl/bufchain_base.sv
module bufchain_base
    import bufchain_pkg::*;
#(
    parameter int ADDR_BYTES = 3,
    parameter int CNT_W      = 16
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    wr_en,
    input  logic [2:0]              wr_sel,
    input  logic [CNT_W-1:0]        wr_data,
    input  logic                    ext_map_en,
    output logic [8*ADDR_BYTES-1:0] nxt_addr,
    output logic [CNT_W-1:0]        nxt_cnt
);
    localparam int ADDR_W  = 8 * ADDR_BYTES;
    localparam int MSB_IDX = ADDR_BYTES - 1;

    logic [ADDR_W-1:0] addr_q;
    logic [CNT_W-1:0]  cnt_q;

    for (genvar b = 0; b < ADDR_BYTES; b++) begin : g_byte
        logic hit;
        assign hit = wr_en && addr_byte_hit(wr_sel, b, MSB_IDX, ext_map_en);
        assign nxt_addr[8*b +: 8] = hit ? wr_data[7:0] : addr_q[8*b +: 8];
    end

    assign nxt_cnt = (wr_en && wr_sel == SEL_CNT) ? wr_data : cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
            cnt_q  <= '0;
        end else begin
            addr_q <= nxt_addr;
            cnt_q  <= nxt_cnt;
        end
    end

    // With the extended region off, the top byte must never move
    AST_MSB_BLOCKED: assert property (@(posedge clk) disable iff (rst)
        (!ext_map_en || !wr_en) |=> $stable(addr_q[ADDR_W-1 -: 8])) else $error("top byte changed"); // R9

endmodule

// File: rtl/bufchain_cur.sv
module bufchain_cur #(
    parameter int ADDR_BYTES = 3,
    parameter int CNT_W      = 16
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    load,
    input  logic [8*ADDR_BYTES-1:0] src_addr,
    input  logic [CNT_W-1:0]        src_cnt,
    output logic [8*ADDR_BYTES-1:0] cur_addr,
    output logic [CNT_W-1:0]        cur_cnt
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cur_addr <= '0;
            cur_cnt  <= '0;
        end else if (load) begin
            cur_addr <= src_addr;
            cur_cnt  <= src_cnt;
        end
    end

    AST_CUR_HOLD: assert property (@(posedge clk) disable iff (rst)
        !load |=> ($stable(cur_addr) && $stable(cur_cnt))) else $error("current set moved"); // R6

    AST_CUR_LOAD: assert property (@(posedge clk) disable iff (rst)
        load |=> (cur_addr == $past(src_addr))) else $error("current set not loaded"); // R5

endmodule

// File: rtl/bufchain_ctl.sv
module bufchain_ctl
    import bufchain_pkg::*;
#(
    parameter int ADDR_BYTES = 3
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic [2:0] wr_sel,
    input  logic       wr_bit0,
    input  logic       ext_map_en,
    input  logic       buf_exp,
    output logic       load,
    output logic       irq,
    output logic       chain_on
);
    localparam int MSB_IDX = ADDR_BYTES - 1;

    logic     mask;
    logic     base_full;
    logic     msb_commit;
    logic     chain_set;
    logic     chain_clr;
    logic     mask_wr;
    logic     exp_ok;
    exp_evt_t evt;

    assign msb_commit = wr_en && addr_byte_hit(wr_sel, MSB_IDX, MSB_IDX, ext_map_en);
    assign chain_set  = wr_en && (wr_sel == SEL_CHAIN) &&  wr_bit0 && !chain_on;
    assign chain_clr  = wr_en && (wr_sel == SEL_CHAIN) && !wr_bit0 &&  chain_on;
    assign mask_wr    = wr_en && (wr_sel == SEL_MASK);
    assign exp_ok     = buf_exp && chain_on && !mask && !chain_set && !chain_clr;

    always_comb begin
        evt = EVT_NONE;
        if (exp_ok) evt = (base_full || msb_commit) ? EVT_LOAD : EVT_TERM;
    end

    assign load = (evt == EVT_LOAD);

    always_ff @(posedge clk) begin
        if (rst) begin
            chain_on  <= 1'b0;
            base_full <= 1'b0;
            irq       <= 1'b0;
            mask      <= 1'b1;
        end else begin
            if (chain_set) begin
                chain_on  <= 1'b1;
                base_full <= 1'b0;
                irq       <= 1'b1;
            end else if (chain_clr) begin
                chain_on  <= 1'b0;
                irq       <= 1'b0;
            end else if (evt == EVT_LOAD) begin
                base_full <= 1'b0;
                irq       <= 1'b1;
            end else if (evt == EVT_TERM) begin
                chain_on  <= 1'b0;
                irq       <= 1'b0;
            end else if (msb_commit) begin
                base_full <= 1'b1;
                irq       <= 1'b0;
            end
            if (mask_wr) mask <= wr_bit0;
        end
    end

    AST_ENTER_RAISES: assert property (@(posedge clk) disable iff (rst)
        chain_set |=> (irq && chain_on && !base_full)) else $error("entry did not raise irq"); // R3

    AST_COMMIT_DROPS: assert property (@(posedge clk) disable iff (rst)
        (msb_commit && evt == EVT_NONE && !chain_set && !chain_clr) |=> (!irq && base_full))
        else $error("commit kept irq"); // R4

    AST_LATE_ENDS: assert property (@(posedge clk) disable iff (rst)
        (evt == EVT_TERM) |=> (!chain_on && !irq)) else $error("late reload kept chain"); // R6

    AST_EXIT_CLEARS: assert property (@(posedge clk) disable iff (rst)
        chain_clr |=> (!chain_on && !irq)) else $error("exit kept irq"); // R7

    AST_MASK_FREEZE: assert property (@(posedge clk) disable iff (rst)
        (mask && !wr_en) |=> ($stable(chain_on) && $stable(irq) && $stable(base_full)))
        else $error("masked channel changed"); // R8

    AST_IRQ_NEEDS_CHAIN: assert property (@(posedge clk) disable iff (rst)
        irq |-> chain_on) else $error("irq without chain"); // R7

endmodule

// File: rtl/bufchain_ctrl.sv
module bufchain_ctrl
    import bufchain_pkg::*;
#(
    parameter int ADDR_BYTES = 3,
    parameter int CNT_W      = 16
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    wr_en,
    input  logic [2:0]              wr_sel,
    input  logic [CNT_W-1:0]        wr_data,
    input  logic                    ext_map_en,
    input  logic                    buf_exp,
    output logic [8*ADDR_BYTES-1:0] cur_addr,
    output logic [CNT_W-1:0]        cur_cnt,
    output logic                    irq,
    output logic                    chain_active
);
    localparam int ADDR_W = 8 * ADDR_BYTES;

    logic [ADDR_W-1:0] stg_addr;
    logic [CNT_W-1:0]  stg_cnt;
    logic              load;

    bufchain_base #(.ADDR_BYTES(ADDR_BYTES), .CNT_W(CNT_W)) u_base (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .wr_sel     (wr_sel),
        .wr_data    (wr_data),
        .ext_map_en (ext_map_en),
        .nxt_addr   (stg_addr),
        .nxt_cnt    (stg_cnt)
    );

    bufchain_ctl #(.ADDR_BYTES(ADDR_BYTES)) u_ctl (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .wr_sel     (wr_sel),
        .wr_bit0    (wr_data[0]),
        .ext_map_en (ext_map_en),
        .buf_exp    (buf_exp),
        .load       (load),
        .irq        (irq),
        .chain_on   (chain_active)
    );

    bufchain_cur #(.ADDR_BYTES(ADDR_BYTES), .CNT_W(CNT_W)) u_cur (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .src_addr (stg_addr),
        .src_cnt  (stg_cnt),
        .cur_addr (cur_addr),
        .cur_cnt  (cur_cnt)
    );

endmodule

// File: tb/sim_bufchain_ctrl.sv
module sim_bufchain_ctrl;
    localparam int AB = 3;
    localparam int CW = 16;
    localparam int AW = 8 * AB;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_en = 1'b0;
    logic [2:0]    wr_sel = 3'd0;
    logic [CW-1:0] wr_data = '0;
    logic          ext_map_en = 1'b1;
    logic          buf_exp = 1'b0;
    logic [AW-1:0] cur_addr;
    logic [CW-1:0] cur_cnt;
    logic          irq;
    logic          chain_active;

    always #5 clk = ~clk;

    bufchain_ctrl #(.ADDR_BYTES(AB), .CNT_W(CW)) u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .ext_map_en(ext_map_en), .buf_exp(buf_exp), .cur_addr(cur_addr),
        .cur_cnt(cur_cnt), .irq(irq), .chain_active(chain_active)
    );

    // Behavioural reference state
    bit          m_chain, m_mask, m_full, m_irq;
    bit [AW-1:0] m_baddr, m_caddr;
    bit [CW-1:0] m_bcnt, m_ccnt;

    int    n_cmp = 0;
    int    n_bad = 0;
    bit    cmp_on = 1'b0;
    string phase = "R1";

    always @(posedge clk) begin
        if (rst) begin
            m_chain = 0; m_mask = 1; m_full = 0; m_irq = 0;
            m_baddr = 0; m_caddr = 0; m_bcnt = 0; m_ccnt = 0;
        end else begin
            bit msb, chg, expv;
            msb = wr_en && wr_sel == 3'd2 && ext_map_en;
            if (wr_en && wr_sel < 3'd3 && (wr_sel != 3'd2 || ext_map_en))
                m_baddr[8*wr_sel +: 8] = wr_data[7:0];
            if (wr_en && wr_sel == 3'd4) m_bcnt = wr_data;
            chg  = wr_en && wr_sel == 3'd5 && (wr_data[0] != m_chain);
            expv = buf_exp && m_chain && !m_mask && !chg;
            if (chg) begin
                m_chain = wr_data[0];
                m_irq   = wr_data[0];
                if (wr_data[0]) m_full = 0;
            end else if (expv) begin
                if (m_full || msb) begin
                    m_caddr = m_baddr; m_ccnt = m_bcnt; m_full = 0; m_irq = 1;
                end else begin
                    m_chain = 0; m_irq = 0;
                end
            end else if (msb) begin
                m_full = 1; m_irq = 0;
            end
            if (wr_en && wr_sel == 3'd6) m_mask = wr_data[0];
        end
    end

    always @(negedge clk) begin
        if (cmp_on) begin
            n_cmp++;
            if (cur_addr !== m_caddr || cur_cnt !== m_ccnt || irq !== m_irq || chain_active !== m_chain) begin
                n_bad++;
                $display("FAIL %s t=%0t act addr=%h cnt=%h irq=%b act=%b exp addr=%h cnt=%h irq=%b act=%b",
                         phase, $time, cur_addr, cur_cnt, irq, chain_active,
                         m_caddr, m_ccnt, m_irq, m_chain);
            end
        end
    end

    task automatic drv(input bit we, input bit [2:0] sel, input bit [CW-1:0] d,
                       input bit ext, input bit ex);
        @(negedge clk);
        wr_en = we; wr_sel = sel; wr_data = d; ext_map_en = ext; buf_exp = ex;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) drv(0, 3'd0, '0, 1, 0);
    endtask

    task automatic wr(input bit [2:0] sel, input bit [CW-1:0] d);
        drv(1, sel, d, 1, 0);
        idle(1);
    endtask

    task automatic expire();
        drv(0, 3'd0, '0, 1, 1);
        idle(1);
    endtask

    initial begin
        bit done;
        done = 1'b0;
        fork
            begin
                idle(3);
                rst = 1'b0;
                cmp_on = 1'b1;
                idle(2);
                phase = "R2"; wr(3'd0, 16'h0012); wr(3'd1, 16'h0034); wr(3'd4, 16'h0100);
                wr(3'd3, 16'h00ff); wr(3'd7, 16'h0001);
                phase = "R11"; expire();
                phase = "R3"; wr(3'd5, 16'h0001); wr(3'd5, 16'h0001);
                phase = "R4"; wr(3'd0, 16'h0012); wr(3'd4, 16'h0100); wr(3'd2, 16'h0056);
                phase = "R8"; expire(); expire(); wr(3'd6, 16'h0000);
                phase = "R5"; expire();
                phase = "R10"; wr(3'd0, 16'h00aa); drv(1, 3'd2, 16'h00bb, 1, 1); idle(2);
                phase = "R6"; expire(); expire();
                phase = "R9"; wr(3'd5, 16'h0001); drv(1, 3'd2, 16'h0077, 0, 0); idle(1);
                wr(3'd1, 16'h00cc); drv(1, 3'd4, 16'h0200, 0, 0); idle(1);
                expire();
                wr(3'd5, 16'h0001); drv(1, 3'd2, 16'h0011, 0, 0); idle(1);
                wr(3'd2, 16'h0066); expire();
                phase = "R7"; wr(3'd5, 16'h0000);
                phase = "R11"; wr(3'd5, 16'h0001); drv(1, 3'd5, 16'h0000, 1, 1); idle(2);
                phase = "R5/R6 mix";
                for (int i = 0; i < 3000; i++) begin
                    bit [2:0] s;
                    s = 3'($urandom_range(0, 7));
                    if (s == 3'd6 && ($urandom_range(0, 3) != 0)) s = 3'd2;
                    drv($urandom_range(0, 2) == 0, s, CW'($urandom),
                        $urandom_range(0, 7) != 0, $urandom_range(0, 3) == 0);
                end
                phase = "R1"; rst = 1'b1; idle(2); rst = 1'b0; idle(2);
                done = 1'b1;
            end
            begin
                repeat (100000) @(posedge clk);
                if (!done) begin
                    n_cmp++; n_bad++;
                    $display("FAIL watchdog act=hung exp=done");
                end
            end
        join_any
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule